// File: doc/BRIEF.md
# Moving Inversions Memory Tester

This block is a self-sequencing test engine for a synchronous single-port RAM with one cycle of read latency. The caller gives it an address window (lowest and highest address, both inclusive), picks one of four data pattern families, and pulses start. The engine then drives the RAM through a fixed request port of address, write data, write enable and read enable, and checks what comes back on the read data input.

Every pass has three sweeps. The first sweep writes the pattern into the whole window. The second sweep moves upward: it reads each word, checks it, and writes back the inverted word. The third sweep moves downward: it reads each word, checks it against that inverted value, and restores the original pattern. A pattern family runs a fixed number of passes, and its pattern changes from one pass to the next.

Mismatches do not stop the run. The first one is captured (address, expected word, observed word). A fail flag stays set until the next start, and a counter that stops at its maximum counts every mismatch. The run ends with a one-cycle done pulse.

Top module: `mi_tester`

## Requirements
- R1: After reset, busy, done and fail are 0, err_count is 0, and neither mem_we nor mem_rd is asserted while the engine is idle.
- R2: Write sweep. Starting the clock cycle after an accepted start, one write is issued per cycle, at every address from lo_addr up to hi_addr, carrying the pass pattern for that address.
- R3: Upward sweep. For each address from lo_addr to hi_addr, a read is issued in one cycle. In the next cycle the engine compares mem_rdata with the pattern and writes the inverted pattern to the same address. A cycle never has both mem_we and mem_rd set.
- R4: Downward sweep. For each address from hi_addr down to lo_addr, a read is issued. In the next cycle the engine compares mem_rdata with the inverted pattern and writes the pattern back. The next pass, if there is one, begins with its write sweep in the following cycle.
- R5: Mode code 0 (solid) runs 2 passes: all zeros in pass 0, then all ones in pass 1.
- R6: Mode code 1 (walking byte) runs 8 passes. In pass p, bit p of every byte is 1 and all other bits are 0.
- R7: Mode code 2 (random) runs RAND_PASSES passes, using one word for the whole window in each pass. Pass 0 uses SEED. Each later pass uses the previous word s shifted left by one, XORed with TAPS when the old MSB of s was 1.
- R8: Mode code 3 (rotating bit) runs DW passes. At offset i = addr - lo_addr in pass p, the pattern has a single 1 at bit (p + i) mod DW.
- R9: The first mismatch of a run latches fail_addr, fail_exp (the word expected) and fail_act (the word read). Later mismatches leave these unchanged. fail rises with the first mismatch and stays at 1 until the next accepted start.
- R10: err_count goes up by one on every mismatch and stops at 2^ECW-1.
- R11: A start pulse while busy has no effect: the request stream, lo/hi and mode of the running test stay as they were.
- R12: done is 1 for exactly one cycle: the cycle after the final downward write. busy goes low in that same cycle. An accepted start clears fail and err_count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Starts a test when idle |
| lo_addr | input | AW | Lowest address of the window |
| hi_addr | input | AW | Highest address of the window (must be at least lo_addr) |
| mode | input | 2 | Pattern family code 0..3 |
| busy | output | 1 | Test in progress |
| done | output | 1 | One-cycle pulse when the test ends |
| fail | output | 1 | Sticky mismatch flag |
| fail_addr | output | AW | Address of the first mismatch |
| fail_exp | output | DW | Expected word at the first mismatch |
| fail_act | output | DW | Observed word at the first mismatch |
| err_count | output | ECW | Saturating mismatch count |
| mem_addr | output | AW | RAM address |
| mem_wdata | output | DW | RAM write data |
| mem_we | output | 1 | RAM write enable |
| mem_rd | output | 1 | RAM read enable |
| mem_rdata | input | DW | RAM read data, valid one cycle after mem_rd |

## Verification
Every request is a function of the sequencer state, so a wrong address counter, a wrong phase or a wrong pass index appears on mem_addr, mem_we, mem_rd or mem_wdata in the very cycle it goes wrong. The bench compares the whole request stream against its own model on every clock. A fault in the pattern or pass logic therefore shows up as soon as the first write of the affected pass is issued. Faults in the compare path only become visible once the run ends, through fail, the captured first-mismatch words and err_count. A RAM model with a stuck bit is used to force known mismatches, and the bench computes the expected mismatch count and first-mismatch record for it.

// File: rtl/mi_pkg.sv
package mi_pkg;

    typedef enum logic [1:0] {
        PM_SOLID = 2'd0,
        PM_WALK  = 2'd1,
        PM_RAND  = 2'd2,
        PM_ROT   = 2'd3
    } pat_mode_e;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_FILL,
        PH_UP_RD,
        PH_UP_WR,
        PH_DN_RD,
        PH_DN_WR
    } phase_e;

    function automatic int unsigned max3(int unsigned a, int unsigned b, int unsigned c);
        int unsigned m;
        m = (a > b) ? a : b;
        return (m > c) ? m : c;
    endfunction

endpackage

// File: rtl/mi_pattern_gen.sv
module mi_pattern_gen
    import mi_pkg::*;
#(
    parameter int AW = 10,
    parameter int DW = 32,
    parameter int PW = 6
) (
    input  pat_mode_e         mode,
    input  logic [PW-1:0]     pass,
    input  logic [AW-1:0]     offset,
    input  logic [DW-1:0]     rnd,
    output logic [DW-1:0]     pat
);
    logic [DW-1:0] walk_pat;
    logic [DW-1:0] rot_pat;
    int            rot_pos;

    // one set bit per byte lane, selected by the pass index
    for (genvar b = 0; b < DW; b++) begin : g_walk
        assign walk_pat[b] = (pass == PW'(b % 8));
    end

    always_comb begin
        rot_pos = (int'(pass) + int'(offset)) % DW;
        rot_pat = {{(DW-1){1'b0}}, 1'b1} << rot_pos;
    end

    always_comb begin
        unique case (mode)
            PM_SOLID: pat = pass[0] ? '1 : '0;
            PM_WALK:  pat = walk_pat;
            PM_RAND:  pat = rnd;
            default:  pat = rot_pat;
        endcase
    end

endmodule

// File: rtl/mi_lfsr.sv
module mi_lfsr #(
    parameter int          DW   = 32,
    parameter logic [DW-1:0] SEED = 32'hACE1_2D5B,
    parameter logic [DW-1:0] TAPS = 32'h8020_0003
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load,
    input  logic          step,
    output logic [DW-1:0] value
);
    always_ff @(posedge clk) begin
        if (rst || load) begin
            value <= SEED;
        end else if (step) begin
            value <= {value[DW-2:0], 1'b0} ^ (value[DW-1] ? TAPS : '0);
        end
    end

endmodule

// File: rtl/mi_err_log.sv
module mi_err_log #(
    parameter int AW  = 10,
    parameter int DW  = 32,
    parameter int ECW = 16
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           clear,
    input  logic           cmp_en,
    input  logic [AW-1:0]  cmp_addr,
    input  logic [DW-1:0]  cmp_exp,
    input  logic [DW-1:0]  cmp_act,
    output logic           fail,
    output logic [AW-1:0]  fail_addr,
    output logic [DW-1:0]  fail_exp,
    output logic [DW-1:0]  fail_act,
    output logic [ECW-1:0] err_count
);
    logic miss;

    assign miss = cmp_en && (cmp_exp != cmp_act);

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            fail      <= 1'b0;
            fail_addr <= '0;
            fail_exp  <= '0;
            fail_act  <= '0;
            err_count <= '0;
        end else if (miss) begin
            if (!fail) begin
                fail      <= 1'b1;
                fail_addr <= cmp_addr;
                fail_exp  <= cmp_exp;
                fail_act  <= cmp_act;
            end
            if (err_count != '1) begin
                err_count <= err_count + 1'b1;
            end
        end
    end

endmodule

// File: rtl/mi_tester.sv
module mi_tester
    import mi_pkg::*;
#(
    parameter int            AW          = 10,
    parameter int            DW          = 32,
    parameter int            ECW         = 16,
    parameter int            RAND_PASSES = 4,
    parameter logic [DW-1:0] SEED        = 32'hACE1_2D5B,
    parameter logic [DW-1:0] TAPS        = 32'h8020_0003
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           start,
    input  logic [AW-1:0]  lo_addr,
    input  logic [AW-1:0]  hi_addr,
    input  logic [1:0]     mode,
    output logic           busy,
    output logic           done,
    output logic           fail,
    output logic [AW-1:0]  fail_addr,
    output logic [DW-1:0]  fail_exp,
    output logic [DW-1:0]  fail_act,
    output logic [ECW-1:0] err_count,
    output logic [AW-1:0]  mem_addr,
    output logic [DW-1:0]  mem_wdata,
    output logic           mem_we,
    output logic           mem_rd,
    input  logic [DW-1:0]  mem_rdata
);
    localparam int MAXP = max3(DW, 8, RAND_PASSES);
    localparam int PW   = $clog2(MAXP + 1);

    phase_e        ph;
    pat_mode_e     mode_q;
    logic [AW-1:0] addr_q, lo_q, hi_q;
    logic [PW-1:0] pass_q, last_pass;
    logic          done_q;
    logic          start_ok, lfsr_step, cmp_en;
    logic [DW-1:0] rnd, pat, exp_word;

    assign start_ok = start && (ph == PH_IDLE);

    always_comb begin
        unique case (mode_q)
            PM_SOLID: last_pass = PW'(1);
            PM_WALK:  last_pass = PW'(7);
            PM_RAND:  last_pass = PW'(RAND_PASSES - 1);
            default:  last_pass = PW'(DW - 1);
        endcase
    end

    assign lfsr_step = (ph == PH_DN_WR) && (addr_q == lo_q) && (pass_q != last_pass);

    mi_lfsr #(.DW(DW), .SEED(SEED), .TAPS(TAPS)) u_lfsr (
        .clk   (clk),
        .rst   (rst),
        .load  (start_ok),
        .step  (lfsr_step),
        .value (rnd)
    );

    mi_pattern_gen #(.AW(AW), .DW(DW), .PW(PW)) u_pat (
        .mode   (mode_q),
        .pass   (pass_q),
        .offset (addr_q - lo_q),
        .rnd    (rnd),
        .pat    (pat)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            ph     <= PH_IDLE;
            mode_q <= PM_SOLID;
            addr_q <= '0;
            lo_q   <= '0;
            hi_q   <= '0;
            pass_q <= '0;
            done_q <= 1'b0;
        end else begin
            done_q <= 1'b0;
            unique case (ph)
                PH_IDLE: if (start) begin
                    ph     <= PH_FILL;
                    mode_q <= pat_mode_e'(mode);
                    lo_q   <= lo_addr;
                    hi_q   <= hi_addr;
                    addr_q <= lo_addr;
                    pass_q <= '0;
                end
                PH_FILL: begin
                    if (addr_q == hi_q) begin
                        ph     <= PH_UP_RD;
                        addr_q <= lo_q;
                    end else begin
                        addr_q <= addr_q + 1'b1;
                    end
                end
                PH_UP_RD: ph <= PH_UP_WR;
                PH_UP_WR: begin
                    if (addr_q == hi_q) begin
                        ph <= PH_DN_RD;
                    end else begin
                        ph     <= PH_UP_RD;
                        addr_q <= addr_q + 1'b1;
                    end
                end
                PH_DN_RD: ph <= PH_DN_WR;
                default: begin
                    if (addr_q != lo_q) begin
                        ph     <= PH_DN_RD;
                        addr_q <= addr_q - 1'b1;
                    end else if (pass_q == last_pass) begin
                        ph     <= PH_IDLE;
                        done_q <= 1'b1;
                    end else begin
                        ph     <= PH_FILL;
                        pass_q <= pass_q + 1'b1;
                    end
                end
            endcase
        end
    end

    assign cmp_en    = (ph == PH_UP_WR) || (ph == PH_DN_WR);
    assign exp_word  = (ph == PH_UP_WR) ? pat : ~pat;
    assign busy      = (ph != PH_IDLE);
    assign done      = done_q;
    assign mem_addr  = addr_q;
    assign mem_we    = (ph == PH_FILL) || cmp_en;
    assign mem_rd    = (ph == PH_UP_RD) || (ph == PH_DN_RD);
    assign mem_wdata = cmp_en ? ~exp_word : pat;

    mi_err_log #(.AW(AW), .DW(DW), .ECW(ECW)) u_log (
        .clk       (clk),
        .rst       (rst),
        .clear     (start_ok),
        .cmp_en    (cmp_en),
        .cmp_addr  (addr_q),
        .cmp_exp   (exp_word),
        .cmp_act   (mem_rdata),
        .fail      (fail),
        .fail_addr (fail_addr),
        .fail_exp  (fail_exp),
        .fail_act  (fail_act),
        .err_count (err_count)
    );

endmodule

// File: rtl/mi_tester_chk.sv
module mi_tester_chk #(
    parameter int AW  = 10,
    parameter int ECW = 16
) (
    input logic           clk,
    input logic           rst,
    input logic           start,
    input logic           busy,
    input logic           done,
    input logic           fail,
    input logic [ECW-1:0] err_count,
    input logic [AW-1:0]  mem_addr,
    input logic           mem_we,
    input logic           mem_rd
);
    // R1
    idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        !busy |-> !(mem_we || mem_rd));

    // R3
    rd_then_wr_chk: assert property (@(posedge clk) disable iff (rst)
        mem_rd |=> (mem_we && mem_addr == $past(mem_addr)));

    // R3
    we_rd_excl_chk: assert property (@(posedge clk) disable iff (rst)
        !(mem_we && mem_rd));

    // R9
    fail_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        (fail && !start) |=> fail);

    // R10
    count_sat_chk: assert property (@(posedge clk) disable iff (rst)
        ((&err_count) && !start) |=> (&err_count));

    // R11
    busy_rise_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> $past(start));

    // R12
    done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R12
    done_idle_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> done);

endmodule

bind mi_tester mi_tester_chk #(.AW(AW), .ECW(ECW)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .start     (start),
    .busy      (busy),
    .done      (done),
    .fail      (fail),
    .err_count (err_count),
    .mem_addr  (mem_addr),
    .mem_we    (mem_we),
    .mem_rd    (mem_rd)
);

// File: tb/mi_tester_test.sv
module mi_tester_test;
    localparam int          AW   = 6;
    localparam int          DW   = 32;
    localparam int          ECW  = 4;
    localparam int          RP   = 3;
    localparam logic [31:0] SEED = 32'hACE1_2D5B;
    localparam logic [31:0] TAPS = 32'h8020_0003;

    logic           clk = 1'b0;
    logic           rst;
    logic           start;
    logic [AW-1:0]  lo_addr, hi_addr;
    logic [1:0]     mode;
    logic           busy, done, fail;
    logic [AW-1:0]  fail_addr;
    logic [DW-1:0]  fail_exp, fail_act;
    logic [ECW-1:0] err_count;
    logic [AW-1:0]  mem_addr;
    logic [DW-1:0]  mem_wdata, mem_rdata;
    logic           mem_we, mem_rd;

    int checks = 0;
    int errors = 0;

    // stuck-bit fault for the RAM model
    logic        flt_en  = 1'b0;
    int          flt_adr = 0;
    int          flt_bit = 0;
    logic        flt_val = 1'b0;

    logic [DW-1:0] ram [0:(1<<AW)-1];
    logic [DW-1:0] ref_mem [0:(1<<AW)-1];

    int            q_op[$];
    int            q_adr[$];
    logic [DW-1:0] q_dat[$];

    int            e_cnt;
    int            e_adr;
    logic [DW-1:0] e_exp, e_act;

    always #2 clk = ~clk;

    mi_tester #(.AW(AW), .DW(DW), .ECW(ECW), .RAND_PASSES(RP),
                .SEED(SEED), .TAPS(TAPS)) uut (
        .clk(clk), .rst(rst), .start(start), .lo_addr(lo_addr),
        .hi_addr(hi_addr), .mode(mode), .busy(busy), .done(done),
        .fail(fail), .fail_addr(fail_addr), .fail_exp(fail_exp),
        .fail_act(fail_act), .err_count(err_count), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_we(mem_we), .mem_rd(mem_rd),
        .mem_rdata(mem_rdata)
    );

    function automatic logic [DW-1:0] inject(int a, logic [DW-1:0] d);
        logic [DW-1:0] r;
        r = d;
        if (flt_en && a == flt_adr) r[flt_bit] = flt_val;
        return r;
    endfunction

    always_ff @(posedge clk) begin
        if (mem_we) ram[mem_addr] <= inject(int'(mem_addr), mem_wdata);
        if (mem_rd) mem_rdata <= ram[mem_addr];
    end

    task automatic check(input string req, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic int pass_count(int m);
        case (m)
            0: return 2;
            1: return 8;
            2: return RP;
            default: return DW;
        endcase
    endfunction

    function automatic logic [DW-1:0] ref_pat(int m, int p, int i, logic [DW-1:0] rv);
        logic [DW-1:0] r;
        r = '0;
        case (m)
            0: r = (p == 0) ? '0 : '1;
            1: for (int j = 0; j < DW / 8; j++) r[8*j + p] = 1'b1;
            2: r = rv;
            default: r[(p + i) % DW] = 1'b1;
        endcase
        return r;
    endfunction

    task automatic push(int op, int a, logic [DW-1:0] d);
        q_op.push_back(op);
        q_adr.push_back(a);
        q_dat.push_back(d);
        if (op == 0) ref_mem[a] = inject(a, d);
    endtask

    task automatic ref_read(int a, logic [DW-1:0] ex);
        push(1, a, '0);
        if (ref_mem[a] !== ex) begin
            if (e_cnt == 0) begin
                e_adr = a; e_exp = ex; e_act = ref_mem[a];
            end
            if (e_cnt < (1 << ECW) - 1) e_cnt++;
        end
    endtask

    task automatic build(int m, int lo, int hi);
        logic [DW-1:0] rv, pt;
        rv = SEED;
        e_cnt = 0; e_adr = 0; e_exp = '0; e_act = '0;
        for (int p = 0; p < pass_count(m); p++) begin
            if (p > 0) rv = {rv[DW-2:0], 1'b0} ^ (rv[DW-1] ? TAPS : '0);
            for (int a = lo; a <= hi; a++) push(0, a, ref_pat(m, p, a - lo, rv));
            for (int a = lo; a <= hi; a++) begin
                pt = ref_pat(m, p, a - lo, rv);
                ref_read(a, pt);
                push(0, a, ~pt);
            end
            for (int a = hi; a >= lo; a--) begin
                pt = ref_pat(m, p, a - lo, rv);
                ref_read(a, ~pt);
                push(0, a, pt);
            end
        end
    endtask

    task automatic run(input int m, input int lo, input int hi,
                       input int poke, input string req);
        int cyc;
        build(m, lo, hi);
        mode = 2'(m); lo_addr = AW'(lo); hi_addr = AW'(hi); start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        cyc = 0;
        while (q_op.size() > 0) begin
            int op, a;
            logic [DW-1:0] d;
            op = q_op.pop_front(); a = q_adr.pop_front(); d = q_dat.pop_front();
            check(req, "busy", 64'(busy), 64'd1);
            check(req, "we", 64'(mem_we), 64'(op == 0));
            check(req, "rd", 64'(mem_rd), 64'(op == 1));
            check(req, "addr", 64'(mem_addr), 64'(a));
            if (op == 0) check(req, "wdata", 64'(mem_wdata), 64'(d));
            if (cyc == poke) begin
                start = 1'b1; mode = 2'(m ^ 1); lo_addr = '0; hi_addr = 1;
            end else begin
                start = 1'b0;
            end
            cyc++;
            @(negedge clk);
        end
        start = 1'b0;
        check("R12", "done at end", 64'(done), 64'd1);
        check("R12", "busy at end", 64'(busy), 64'd0);
        check("R9", "fail", 64'(fail), 64'(e_cnt != 0));
        check("R9", "fail_addr", 64'(fail_addr), 64'(e_adr));
        check("R9", "fail_exp", 64'(fail_exp), 64'(e_exp));
        check("R9", "fail_act", 64'(fail_act), 64'(e_act));
        check("R10", "err_count", 64'(err_count), 64'(e_cnt));
        @(negedge clk);
        check("R12", "done one cycle", 64'(done), 64'd0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        rst = 1'b1; start = 1'b0; mode = '0; lo_addr = '0; hi_addr = '0;
        for (int i = 0; i < (1 << AW); i++) ram[i] = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        check("R1", "busy", 64'(busy), 64'd0);
        check("R1", "done", 64'(done), 64'd0);
        check("R1", "fail", 64'(fail), 64'd0);
        check("R1", "err_count", 64'(err_count), 64'd0);
        check("R1", "requests", 64'(mem_we | mem_rd), 64'd0);

        // R2 R3 R4 R5 solid patterns
        run(0, 3, 10, -1, "R5");
        // R6 walking byte
        run(1, 0, 5, -1, "R6");
        // R7 random, with a start poke mid-run for R11
        run(2, 20, 27, 7, "R11");
        // R8 rotating bit
        run(3, 40, 47, -1, "R8");

        // R9 stuck bit 3 at address 5: mismatch in pass 0 upward and pass 1 downward
        flt_en = 1'b1; flt_adr = 5; flt_bit = 3; flt_val = 1'b1;
        run(0, 2, 9, -1, "R9");
        // R10 many mismatches in rotating mode saturate the counter
        flt_adr = 41; flt_bit = 0;
        run(3, 40, 47, -1, "R10");
        // R12 a new start clears fail and count
        flt_en = 1'b0;
        run(0, 40, 47, -1, "R12");

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule